// File: doc/BRIEF.md
# Serial Audio Link Frame Engine

This block is the controller end of a five-wire serial audio link. The codec supplies the bit clock; the block generates the frame marker, shifts thirteen time-division slots out on the outbound data line and collects thirteen slots from the inbound data line in every frame. With the default sizes a frame is 256 bit clocks long: a 16-bit tag slot followed by twelve 20-bit slots. At a 12.288 MHz bit clock this gives a 48 kHz frame rate.

The host sees parallel slot registers. On the transmit side these are a tag word, a command address, a command data word and ten payload slots, all sampled once at the start of each frame. On the receive side the same layout is published at the end of each complete frame, together with a one-cycle completion strobe. The block also drives the active-low codec reset from a host request. While that reset is low, and for one bit clock after it is released, the frame marker and the outbound data line are held low.

Top module: `aclink_frame_engine`

## Requirements
- R1: A running link repeats its frame every 256 bit clocks, so the frame marker rises once every 256 cycles.
- R2: The frame marker is high for the 16 cycles of the tag slot (frame bits 0 to 15) and low for the other 240 cycles of the frame.
- R3: Outbound bits leave most significant bit first in this slot order: the tag (16 bits), then slot 1 = `tx_cmd_addr`, slot 2 = `tx_cmd_data`, then slots 3 to 12 = `tx_pcm[(k-3)*20 +: 20]` for slot k. Each slot is 20 bits wide. A new bit appears after each rising clock edge.
- R4: The transmit inputs are sampled only at the edge that starts a frame. A change made after that edge shows up in the next frame and not in the current one. A change made during the last bit of a frame is used by the frame that follows it.
- R5: Inbound data is sampled on the falling clock edge and unpacked with the layout of R3 into `rx_tag`, `rx_stat_addr`, `rx_stat_data` and `rx_pcm`. The new values become visible in the cycle that carries bit 0 of the next frame.
- R6: `frame_done` is high for exactly one cycle per completed frame, in the same cycle that the receive registers change.
- R7: `codec_rst_n` is low while the system reset is active. After that, it goes low in the cycle after a high `codec_rst_req` is sampled and goes high in the cycle after a low request is sampled.
- R8: The frame marker and outbound data are low in every cycle in which `codec_rst_n` is low, and also in the first cycle after it rises.
- R9: After the codec reset is released, the first frame starts at bit 0, with the frame marker rising in the second cycle in which `codec_rst_n` is high. A frame cut short by the codec reset produces no `frame_done` and does not change the receive registers. A frame whose last bit was already on the line when the reset request was sampled still completes.
- R10: Between completion strobes, the receive registers hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock from the codec |
| rst_n | input | 1 | Asynchronous active-low system reset, released synchronously inside the block |
| codec_rst_req | input | 1 | Host request to hold the codec in reset |
| tx_tag | input | 16 | Outbound tag slot |
| tx_cmd_addr | input | 20 | Outbound slot 1, command address |
| tx_cmd_data | input | 20 | Outbound slot 2, command data |
| tx_pcm | input | 200 | Outbound slots 3 to 12, 20 bits each, slot 3 in the low bits |
| sdi | input | 1 | Inbound serial data from the codec |
| sync | output | 1 | Frame marker |
| sdo | output | 1 | Outbound serial data |
| codec_rst_n | output | 1 | Active-low codec reset |
| rx_tag | output | 16 | Inbound tag slot of the last complete frame |
| rx_stat_addr | output | 20 | Inbound slot 1 |
| rx_stat_data | output | 20 | Inbound slot 2 |
| rx_pcm | output | 200 | Inbound slots 3 to 12, slot 3 in the low bits |
| frame_done | output | 1 | One-cycle strobe when a frame has been received |

## Verification
Frame completion and a codec reset request can land on the same clock edge. This is the case where the request is sampled at the edge that ends bit 255. The bench provokes it by raising the request during the last bit, and once more during bit 100 and bit 5 for contrast. In the next cycle it judges that the link has gone quiet and that the reset is low. It also judges that the completion strobe and the new receive values appear only when the last bit had already been received. A second collision is a host write made during bit 255, at the same edge that loads the next frame. The bench checks that this write goes entirely into the following frame, while writes made at bit 0 or in mid-frame wait one frame.

// File: rtl/aclink_pkg.sv
`timescale 1ns/1ps
package aclink_pkg;
  localparam int DEF_TAG_W     = 16;
  localparam int DEF_SLOT_W    = 20;
  localparam int DEF_NUM_SLOTS = 13;

  typedef enum logic {
    LINK_IDLE = 1'b0,
    LINK_RUN  = 1'b1
  } link_state_e;
endpackage

// File: rtl/aclink_reset_ctrl.sv
`timescale 1ns/1ps
module aclink_reset_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic rst_req_i,
  output logic srst_n_o,
  output logic codec_rst_n_o,
  output logic run_next_o
);
  logic [1:0] rsync_q;
  logic       codec_q;
  logic       codec_d;

  // asynchronous assertion, release after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign srst_n_o = rsync_q[1];

  always_comb codec_d = !rst_req_i;

  always_ff @(posedge clk or negedge srst_n_o) begin
    if (!srst_n_o) codec_q <= 1'b0;
    else           codec_q <= codec_d;
  end

  // the link may run in the next cycle only if the codec reset is already
  // high now and stays high: this leaves one quiet cycle after release
  assign run_next_o    = codec_d && codec_q;
  assign codec_rst_n_o = codec_q;
endmodule

// File: rtl/aclink_bit_timer.sv
`timescale 1ns/1ps
module aclink_bit_timer
  import aclink_pkg::*;
#(
  parameter  int FRAME_BITS = 256,
  parameter  int TAG_W      = 16,
  localparam int POS_W      = $clog2(FRAME_BITS)
) (
  input  logic clk,
  input  logic srst_n,
  input  logic run_next_i,
  output logic running_o,
  output logic load_o,
  output logic last_o,
  output logic sync_o
);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_BITS - 1);
  localparam logic [POS_W-1:0] TAG_END  = POS_W'(TAG_W);

  link_state_e      state_q, state_d;
  logic [POS_W-1:0] pos_q, pos_d;
  logic             sync_q, sync_d;

  always_comb begin
    state_d = state_q;
    pos_d   = pos_q;
    if (!run_next_i) begin
      state_d = LINK_IDLE;
      pos_d   = '0;
    end else if (state_q == LINK_IDLE) begin
      state_d = LINK_RUN;
      pos_d   = '0;
    end else if (pos_q == LAST_POS) begin
      pos_d   = '0;
    end else begin
      pos_d   = pos_q + POS_W'(1);
    end
    sync_d = (state_d == LINK_RUN) && (pos_d < TAG_END);
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state_q <= LINK_IDLE;
      pos_q   <= '0;
      sync_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pos_q   <= pos_d;
      sync_q  <= sync_d;
    end
  end

  assign load_o    = (state_d == LINK_RUN) && (pos_d == '0);
  assign running_o = (state_q == LINK_RUN);
  assign last_o    = running_o && (pos_q == LAST_POS);
  assign sync_o    = sync_q;
endmodule

// File: rtl/aclink_tx_shifter.sv
`timescale 1ns/1ps
module aclink_tx_shifter #(
  parameter int FRAME_BITS = 256
) (
  input  logic                  clk,
  input  logic                  srst_n,
  input  logic                  keep_i,
  input  logic                  load_i,
  input  logic [FRAME_BITS-1:0] frame_i,
  output logic                  sdo_o
);
  logic [FRAME_BITS-1:0] sr_q, sr_d;

  always_comb begin
    if (!keep_i)     sr_d = '0;
    else if (load_i) sr_d = frame_i;
    else             sr_d = {sr_q[FRAME_BITS-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) sr_q <= '0;
    else         sr_q <= sr_d;
  end

  assign sdo_o = sr_q[FRAME_BITS-1];
endmodule

// File: rtl/aclink_rx_deser.sv
`timescale 1ns/1ps
module aclink_rx_deser #(
  parameter int FRAME_BITS = 256
) (
  input  logic                  clk,
  input  logic                  srst_n,
  input  logic                  sdi_i,
  input  logic                  shift_en_i,
  input  logic                  last_i,
  output logic [FRAME_BITS-1:0] frame_o,
  output logic                  done_o
);
  logic                  sdi_fall_q;
  logic [FRAME_BITS-1:0] sr_q, sr_d;
  logic [FRAME_BITS-1:0] frame_q;
  logic                  done_q;

  // inbound bit sampled mid-cycle on the falling edge
  always_ff @(negedge clk or negedge srst_n) begin
    if (!srst_n) sdi_fall_q <= 1'b0;
    else         sdi_fall_q <= sdi_i;
  end

  always_comb sr_d = {sr_q[FRAME_BITS-2:0], sdi_fall_q};

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) sr_q <= '0;
    else if (shift_en_i) sr_q <= sr_d;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) frame_q <= '0;
    else if (last_i) frame_q <= sr_d;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) done_q <= 1'b0;
    else         done_q <= last_i;
  end

  assign frame_o = frame_q;
  assign done_o  = done_q;
endmodule

// File: rtl/aclink_frame_engine.sv
`timescale 1ns/1ps
module aclink_frame_engine
  import aclink_pkg::*;
#(
  parameter  int TAG_W      = DEF_TAG_W,
  parameter  int SLOT_W     = DEF_SLOT_W,
  parameter  int NUM_SLOTS  = DEF_NUM_SLOTS,
  localparam int PCM_SLOTS  = NUM_SLOTS - 3,
  localparam int PCM_W      = PCM_SLOTS * SLOT_W,
  localparam int FRAME_BITS = TAG_W + (NUM_SLOTS - 1) * SLOT_W
) (
  input  logic              bclk,
  input  logic              rst_n,
  input  logic              codec_rst_req,
  input  logic [TAG_W-1:0]  tx_tag,
  input  logic [SLOT_W-1:0] tx_cmd_addr,
  input  logic [SLOT_W-1:0] tx_cmd_data,
  input  logic [PCM_W-1:0]  tx_pcm,
  input  logic              sdi,
  output logic              sync,
  output logic              sdo,
  output logic              codec_rst_n,
  output logic [TAG_W-1:0]  rx_tag,
  output logic [SLOT_W-1:0] rx_stat_addr,
  output logic [SLOT_W-1:0] rx_stat_data,
  output logic [PCM_W-1:0]  rx_pcm,
  output logic              frame_done
);
  logic                  srst_n;
  logic                  run_next;
  logic                  running;
  logic                  load;
  logic                  last_bit;
  logic [FRAME_BITS-1:0] tx_frame;
  logic [FRAME_BITS-1:0] rx_frame;

  aclink_reset_ctrl u_rst (
    .clk           (bclk),
    .rst_n         (rst_n),
    .rst_req_i     (codec_rst_req),
    .srst_n_o      (srst_n),
    .codec_rst_n_o (codec_rst_n),
    .run_next_o    (run_next)
  );

  aclink_bit_timer #(.FRAME_BITS(FRAME_BITS), .TAG_W(TAG_W)) u_timer (
    .clk        (bclk),
    .srst_n     (srst_n),
    .run_next_i (run_next),
    .running_o  (running),
    .load_o     (load),
    .last_o     (last_bit),
    .sync_o     (sync)
  );

  // slot layout: tag at the top, then slots 1..NUM_SLOTS-1 downwards
  assign tx_frame[FRAME_BITS-1 -: TAG_W] = tx_tag;
  assign rx_tag = rx_frame[FRAME_BITS-1 -: TAG_W];

  for (genvar s = 1; s < NUM_SLOTS; s++) begin : g_slot
    localparam int HI = FRAME_BITS - TAG_W - (s - 1) * SLOT_W - 1;
    if (s == 1) begin : g_addr
      assign tx_frame[HI -: SLOT_W] = tx_cmd_addr;
      assign rx_stat_addr           = rx_frame[HI -: SLOT_W];
    end else if (s == 2) begin : g_data
      assign tx_frame[HI -: SLOT_W] = tx_cmd_data;
      assign rx_stat_data           = rx_frame[HI -: SLOT_W];
    end else begin : g_pcm
      assign tx_frame[HI -: SLOT_W]               = tx_pcm[(s-3)*SLOT_W +: SLOT_W];
      assign rx_pcm[(s-3)*SLOT_W +: SLOT_W]       = rx_frame[HI -: SLOT_W];
    end
  end

  aclink_tx_shifter #(.FRAME_BITS(FRAME_BITS)) u_tx (
    .clk     (bclk),
    .srst_n  (srst_n),
    .keep_i  (run_next),
    .load_i  (load),
    .frame_i (tx_frame),
    .sdo_o   (sdo)
  );

  aclink_rx_deser #(.FRAME_BITS(FRAME_BITS)) u_rx (
    .clk        (bclk),
    .srst_n     (srst_n),
    .sdi_i      (sdi),
    .shift_en_i (running),
    .last_i     (last_bit),
    .frame_o    (rx_frame),
    .done_o     (frame_done)
  );
endmodule

// File: rtl/aclink_frame_engine_chk.sv
`timescale 1ns/1ps
module aclink_frame_engine_chk #(
  parameter int TAG_W      = 16,
  parameter int PCM_W      = 200,
  parameter int FRAME_BITS = 256
) (
  input logic             clk,
  input logic             rst_n,
  input logic             codec_rst_n,
  input logic             sync,
  input logic             sdo,
  input logic             frame_done,
  input logic [TAG_W-1:0] rx_tag,
  input logic [PCM_W-1:0] rx_pcm
);
  int unsigned hi_cnt;
  int unsigned gap_cnt;
  logic        seen_rise;
  logic        sync_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt    <= 0;
      gap_cnt   <= 0;
      seen_rise <= 1'b0;
      sync_prev <= 1'b0;
    end else begin
      sync_prev <= sync;
      hi_cnt    <= (codec_rst_n && sync) ? hi_cnt + 1 : 0;
      if (!codec_rst_n) begin
        seen_rise <= 1'b0;
        gap_cnt   <= 0;
      end else if (sync && !sync_prev) begin
        seen_rise <= 1'b1;
        gap_cnt   <= 1;
      end else begin
        gap_cnt   <= gap_cnt + 1;
      end
    end
  end

  // R1: marker rises exactly one frame after the previous rise
  p_frame_period_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (codec_rst_n && sync && !sync_prev && seen_rise) |-> (gap_cnt == FRAME_BITS));

  // R2: an uninterrupted marker lasts exactly the tag slot
  p_tag_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (codec_rst_n && $fell(sync)) |-> (hi_cnt == TAG_W));

  // R6: completion strobe is a single cycle
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  // R8: link quiet while the codec is held in reset
  p_reset_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !codec_rst_n |-> (!sync && !sdo));

  // R8: still quiet in the release cycle
  p_release_guard_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(codec_rst_n) |-> (!sync && !sdo));

  // R10: receive registers only move with the strobe
  p_rx_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done |-> ($stable(rx_tag) && $stable(rx_pcm)));
endmodule

bind aclink_frame_engine aclink_frame_engine_chk #(
  .TAG_W      (TAG_W),
  .PCM_W      (PCM_W),
  .FRAME_BITS (FRAME_BITS)
) u_chk (
  .clk         (bclk),
  .rst_n       (rst_n),
  .codec_rst_n (codec_rst_n),
  .sync        (sync),
  .sdo         (sdo),
  .frame_done  (frame_done),
  .rx_tag      (rx_tag),
  .rx_pcm      (rx_pcm)
);

// File: tb/aclink_frame_engine_tb.sv
`timescale 1ns/1ps
module aclink_frame_engine_tb;
  localparam int FB = 256;
  localparam logic [31:0] SA = 32'h0000_1234;
  localparam logic [31:0] SB = 32'h000A_BCD5;

  logic         bclk;
  logic         rst_n;
  logic         codec_rst_req;
  logic [15:0]  tx_tag;
  logic [19:0]  tx_cmd_addr, tx_cmd_data;
  logic [199:0] tx_pcm;
  logic         sdi;
  logic         sync, sdo, codec_rst_n, frame_done;
  logic [15:0]  rx_tag;
  logic [19:0]  rx_stat_addr, rx_stat_data;
  logic [199:0] rx_pcm;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  reported = 0;
  int  cur_f;
  logic [FB-1:0] rx_latched;

  aclink_frame_engine u_dut (
    .bclk(bclk), .rst_n(rst_n), .codec_rst_req(codec_rst_req),
    .tx_tag(tx_tag), .tx_cmd_addr(tx_cmd_addr), .tx_cmd_data(tx_cmd_data),
    .tx_pcm(tx_pcm), .sdi(sdi), .sync(sync), .sdo(sdo),
    .codec_rst_n(codec_rst_n), .rx_tag(rx_tag), .rx_stat_addr(rx_stat_addr),
    .rx_stat_data(rx_stat_data), .rx_pcm(rx_pcm), .frame_done(frame_done)
  );

  initial bclk = 1'b0;
  always #2.5 bclk = ~bclk;

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic check(input bit ok, input string req,
                       input logic [FB-1:0] act, input logic [FB-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge bclk);
    #1;
  endtask

  function automatic logic [19:0] slot_val(input int f, input int s, input logic [31:0] salt);
    logic [31:0] t;
    if (f == 0) return 20'h0;
    if (f == 1) return 20'hFFFFF;
    t = (32'(s + 1) * 32'h0009_E377) ^ (32'(f) * 32'h0005_1ED3) ^ salt;
    return t[19:0];
  endfunction

  function automatic logic [FB-1:0] exp_frame(input int f, input logic [31:0] salt);
    logic [FB-1:0] v;
    logic [19:0]   w;
    v = '0;
    w = slot_val(f, 0, salt);
    v[FB-1 -: 16] = w[15:0];
    for (int s = 1; s < 13; s++) v[FB-17-(s-1)*20 -: 20] = slot_val(f, s, salt);
    return v;
  endfunction

  task automatic set_tx(input int f);
    logic [19:0] w;
    w = slot_val(f, 0, SA);
    tx_tag      = w[15:0];
    tx_cmd_addr = slot_val(f, 1, SA);
    tx_cmd_data = slot_val(f, 2, SA);
    for (int s = 3; s < 13; s++) tx_pcm[(s-3)*20 +: 20] = slot_val(f, s, SA);
  endtask

  function automatic logic [FB-1:0] pack_rx();
    logic [FB-1:0] v;
    v = '0;
    v[FB-1 -: 16] = rx_tag;
    v[FB-17 -: 20] = rx_stat_addr;
    v[FB-37 -: 20] = rx_stat_data;
    for (int s = 3; s < 13; s++) v[FB-17-(s-1)*20 -: 20] = rx_pcm[(s-3)*20 +: 20];
    return v;
  endfunction

  // entered in the cycle carrying bit 0; leaves in bit 0 of the next frame
  task automatic run_frame(input logic [FB-1:0] exp_tx, input logic [FB-1:0] rxv,
                           input int chg_at, input int chg_f);
    logic [FB-1:0] cap, rx0;
    bit sync_ok = 1, done_ok = 1, hold_ok = 1;
    rx0 = pack_rx();
    for (int i = 0; i < FB; i++) begin
      cap[FB-1-i] = sdo;
      if (sync != (i < 16)) sync_ok = 0;
      if (i > 0 && frame_done) done_ok = 0;
      if (pack_rx() != rx0) hold_ok = 0;
      sdi = rxv[FB-1-i];
      if (i == chg_at) set_tx(chg_f);
      step();
    end
    check(cap == exp_tx, (chg_at > 0 && chg_at < FB-1) ? "R4 frame kept" : "R3 order", cap, exp_tx);
    check(sync_ok, "R2 marker width", FB'(sync_ok), FB'(1));
    check(done_ok, "R6 no stray strobe", FB'(done_ok), FB'(1));
    check(hold_ok, "R10 rx hold", FB'(hold_ok), FB'(1));
    check(sync == 1'b1, "R1 period 256", FB'(sync), FB'(1));
    check(frame_done == 1'b1, "R6 strobe", FB'(frame_done), FB'(1));
    check(pack_rx() == rxv, "R5 rx unpack", pack_rx(), rxv);
    rx_latched = rxv;
  endtask

  // entered in bit 0; request raised during bit k; leaves in bit 0 of a fresh frame
  task automatic reset_mid(input int k, input logic [FB-1:0] rxv);
    bit quiet = 1;
    for (int i = 0; i <= k; i++) begin
      sdi = rxv[FB-1-i];
      if (i == k) codec_rst_req = 1'b1;
      step();
    end
    sdi = 1'b0;
    check(codec_rst_n == 1'b0, "R7 reset asserted", FB'(codec_rst_n), FB'(0));
    check(!sync && !sdo, "R8 quiet in reset", FB'({sync, sdo}), FB'(0));
    check(frame_done == (k == FB-1), "R9 completion vs reset", FB'(frame_done), FB'(k == FB-1));
    if (k == FB-1) rx_latched = rxv;
    check(pack_rx() == rx_latched, "R9 rx after reset", pack_rx(), rx_latched);
    for (int i = 0; i < 6; i++) begin
      step();
      if (sync || sdo || frame_done || codec_rst_n) quiet = 0;
    end
    check(quiet, "R8 held quiet", FB'(quiet), FB'(1));
    check(pack_rx() == rx_latched, "R10 rx held in reset", pack_rx(), rx_latched);
    codec_rst_req = 1'b0;
    step();
    check(codec_rst_n == 1'b1, "R7 reset released", FB'(codec_rst_n), FB'(1));
    check(!sync && !sdo, "R8 release cycle quiet", FB'({sync, sdo}), FB'(0));
    step();
    check(sync == 1'b1, "R9 fresh frame start", FB'(sync), FB'(1));
  endtask

  initial begin
    repeat (50000) @(posedge bclk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
    report();
  end

  initial begin
    int c, t_rel, nxt;
    rst_n = 1'b0;
    codec_rst_req = 1'b0;
    sdi = 1'b0;
    tx_pcm = '0;
    set_tx(0);
    cur_f = 0;
    rx_latched = '0;
    repeat (3) step();
    check(codec_rst_n == 1'b0, "R7 reset state", FB'(codec_rst_n), FB'(0));
    check(!sync && !sdo && !frame_done, "R8 reset state quiet", FB'({sync, sdo, frame_done}), FB'(0));
    check(pack_rx() == '0, "R10 reset state rx", pack_rx(), '0);
    rst_n = 1'b1;
    c = 0;
    t_rel = -1;
    while (!sync && c < 20) begin
      step();
      c++;
      if (codec_rst_n && t_rel < 0) t_rel = c;
    end
    check(sync && (c - t_rel) == 1, "R9 first marker after release",
          FB'(c - t_rel), FB'(1));

    // sweep: tx patterns 0..12, host writes at bit 0, mid-frame and last bit
    for (int j = 1; j <= 12; j++) begin
      int at;
      at = (j % 3 == 0) ? 0 : (j % 3 == 1) ? 128 : FB-1;
      run_frame(exp_frame(cur_f, SA), exp_frame(100 + j, SB), at, j);
      cur_f = j;
      if (at == FB-1) begin
        // R4: written during the last bit, so this frame already carries it
        run_frame(exp_frame(cur_f, SA), exp_frame(150 + j, SB), 999, cur_f);
      end
    end

    nxt = cur_f;
    reset_mid(100, exp_frame(200, SB));
    run_frame(exp_frame(nxt, SA), exp_frame(201, SB), 999, nxt);
    reset_mid(FB-1, exp_frame(202, SB));
    run_frame(exp_frame(nxt, SA), exp_frame(203, SB), 999, nxt);
    reset_mid(5, exp_frame(204, SB));
    run_frame(exp_frame(nxt, SA), exp_frame(205, SB), 999, nxt);
    report();
  end
endmodule